// File: doc/BRIEF.md
# I2C Slave Front End with Four-Level Address Pins

This block is the serial front end of a small memory-style I2C target. It watches an oversampled clock line and data line, recognises START, STOP and repeated START, compares the first byte of each transfer against its own 7-bit address, and then moves whole bytes between the bus and a byte-wide port on the core side. It drives the data line only through an open-drain pull-down enable. It has no clock output, so it can never hold the clock line low.

The low four bits of the address are not set by a register. They come from two board-level strap pins. Each strap can be tied to ground, tied to the supply, wired to the clock line or wired to the data line. After reset the block watches both straps while traffic passes on the bus. It works out which of the four connections each strap has and builds its address from the result. Until the straps are classified, the block answers no address at all.

When the core asserts a busy input, or a refuse input, the block declines both address and data bytes by leaving the acknowledge slot high. Read data is fetched from the core one byte at a time, at the clock falling edge that opens the byte.

Top module: `i2cq_quad_addr_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the device address. The upper three address bits are fixed at binary 101 and the lower four come from the straps.
- R2: Each strap yields a 2-bit code: tied low is 00, tied high is 01, follows the clock line is 10 and follows the data line is 11. Strap 0 gives address bits 1:0 and strap 1 gives bits 3:2. After classification `dev_addr_o` holds the address and stays fixed until the next reset.
- R3: Classification ends after `WIN_EDGES` clock-line edges counted from reset. A strap that equalled the clock line at every clock-line edge is coded 10. A strap that equalled the data line at every data-line edge is coded 11. Otherwise the strap level at the end of the window decides. Until then `addr_ready_o` is low and no byte is acknowledged.
- R4: In a write transfer, each data byte is taken most significant bit first on clock rising edges. When the byte is accepted, `rx_valid_o` pulses for one cycle with the byte on `rx_data_o`, and the block acknowledges it.
- R5: When the address byte ends with a 1 (a master read), `tx_data_i` is sampled and `tx_load_o` pulses at the clock falling edge that ends the acknowledge slot. That byte is then driven most significant bit first, with each bit changed after a falling edge of the clock.
- R6: If the master leaves its acknowledge slot high after a read byte, the block stops driving and keeps the data line released until the next START. If the master pulls the slot low, the next byte is loaded and sent.
- R7: While `busy_i` or `refuse_i` is high at the eighth bit of a byte, that byte is not acknowledged, and a refused write byte gives no `rx_valid_o` pulse.
- R8: A START or STOP at any point, including in the middle of a byte, releases the data line and returns the block to waiting for an address. A repeated START is followed by a new address byte.
- R9: After an address that does not match, the data line stays released through all later bytes until the next START.
- R10: The drive enable changes only just after a clock falling edge, or on a START or STOP. The line is therefore stable while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Four-level address straps (bit 0 gives A1:A0, bit 1 gives A3:A2) |
| busy_i | input | 1 | Core busy; forces NACK |
| refuse_i | input | 1 | Core refuses the current byte; forces NACK |
| tx_data_i | input | 8 | Byte to return in the next read slot |
| sda_oe_o | output | 1 | Pull data line low when high |
| rx_data_o | output | 8 | Last accepted write byte |
| rx_valid_o | output | 1 | One-cycle pulse for an accepted write byte |
| tx_load_o | output | 1 | One-cycle pulse when `tx_data_i` is captured |
| addr_ready_o | output | 1 | Strap classification finished |
| dev_addr_o | output | 7 | Resulting 7-bit device address |

## Verification
The bench classifies every strap connection on both straps and uses the same transfer that trains the straps as an attempt to reach the device too early. A classifier that ends its window late, or mixes up a strap that follows the data line with a static level, produces a wrong address or an acknowledge during the window. Directed transfers cover several cases: a START arriving in the middle of a byte, a master NACK followed by more clock pulses, a non-matching address followed by data, and busy or refuse raised on address and on data bytes. A design that misses any of these would drive the line when it should be silent or raise `rx_valid_o`. Every read bit is sampled at both ends of the clock high phase, which catches a slave that changes data on the rising edge.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  localparam logic [2:0] ADDR_FIXED_HI = 3'b101;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_HIGH = 2'b01,
    STRAP_SCL  = 2'b10,
    STRAP_SDA  = 2'b11
  } strap_code_t;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_RX,
    ENG_ACK,
    ENG_TX,
    ENG_MACK
  } eng_state_t;

  // Turn the observations of one strap into its 2-bit code.
  function automatic logic [1:0] strap_decide(input logic follows_scl,
                                              input logic follows_sda,
                                              input logic level);
    if (follows_scl)      return STRAP_SCL;
    else if (follows_sda) return STRAP_SDA;
    else if (level)       return STRAP_HIGH;
    else                  return STRAP_LOW;
  endfunction

  function automatic logic [6:0] build_addr(input logic [1:0] hi_code,
                                            input logic [1:0] lo_code);
    return {ADDR_FIXED_HI, hi_code, lo_code};
  endfunction

endpackage

// File: rtl/i2cq_bus_edges.sv
module i2cq_bus_edges #(
  parameter int NSTRAP = 2,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [NSTRAP-1:0] strap_i,
  output logic              scl_s,
  output logic              sda_s,
  output logic [NSTRAP-1:0] strap_s,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              sda_edge,
  output logic              start_ev,
  output logic              stop_ev
);
  localparam int W = NSTRAP + 2;

  logic [W-1:0] stage [DEPTH];
  logic         scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '1;
    else        stage[0] <= {strap_i, sda_i, scl_i};
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[k] <= '1;
      else        stage[k] <= stage[k-1];
    end
  end

  assign {strap_s, sda_s, scl_s} = stage[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign sda_edge = sda_s ^ sda_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cq_strap_classify.sv
module i2cq_strap_classify #(
  parameter int WIN_EDGES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_s,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_edge,
  input  logic       sda_edge,
  output logic [1:0] code,
  output logic       ready
);
  import i2cq_pkg::*;
  localparam int CW = $clog2(WIN_EDGES + 1);

  logic [CW-1:0] edge_cnt;
  logic scl_ok, sda_ok, seen_scl, seen_sda;
  logic scl_ok_n, sda_ok_n, seen_sda_n, last_edge;

  always_comb begin
    scl_ok_n   = scl_ok & ~(scl_edge & (strap_s != scl_s));
    sda_ok_n   = sda_ok & ~(sda_edge & (strap_s != sda_s));
    seen_sda_n = seen_sda | sda_edge;
    last_edge  = scl_edge && (edge_cnt == CW'(WIN_EDGES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      scl_ok   <= 1'b1;
      sda_ok   <= 1'b1;
      seen_scl <= 1'b0;
      seen_sda <= 1'b0;
      ready    <= 1'b0;
      code     <= STRAP_LOW;
    end else if (!ready) begin
      scl_ok   <= scl_ok_n;
      sda_ok   <= sda_ok_n;
      seen_sda <= seen_sda_n;
      if (scl_edge) begin
        seen_scl <= 1'b1;
        edge_cnt <= edge_cnt + 1'b1;
      end
      if (last_edge) begin
        ready <= 1'b1;
        code  <= strap_decide(scl_ok_n, sda_ok_n & seen_sda_n, strap_s);
      end
    end
  end

  logic unused_seen;
  assign unused_seen = seen_scl;
endmodule

// File: rtl/i2cq_byte_engine.sv
module i2cq_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [6:0] dev_addr,
  input  logic       addr_ready,
  input  logic       busy,
  input  logic       refuse,
  input  logic [7:0] tx_data,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       tx_load
);
  import i2cq_pkg::*;

  eng_state_t st;
  logic [7:0] sr;
  logic [3:0] cnt;
  logic       is_addr, rw, ack_ok, mack;
  logic [7:0] byte_n;
  logic       accept_n;

  always_comb begin
    byte_n = {sr[6:0], sda_s};
    if (is_addr) accept_n = addr_ready && (byte_n[7:1] == dev_addr) && !busy && !refuse;
    else         accept_n = !busy && !refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ENG_IDLE; sr <= '0; cnt <= '0; sda_oe <= 1'b0;
      is_addr <= 1'b0; rw <= 1'b0; ack_ok <= 1'b0; mack <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; tx_load <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (start_ev) begin
        st <= ENG_RX; is_addr <= 1'b1; rw <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= ENG_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ENG_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sr  <= byte_n;
              cnt <= cnt + 1'b1;
              if (cnt == 4'd7) begin
                ack_ok <= accept_n;
                if (is_addr) rw <= sda_s;
                if (!is_addr && accept_n) begin
                  rx_valid <= 1'b1;
                  rx_data  <= byte_n;
                end
              end
            end else if (scl_fall && cnt == 4'd8) begin
              st     <= ack_ok ? ENG_ACK : ENG_IDLE;
              sda_oe <= ack_ok;
            end
          end
          ENG_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sr <= tx_data; tx_load <= 1'b1; sda_oe <= ~tx_data[7]; st <= ENG_TX;
            end else begin
              sda_oe <= 1'b0; is_addr <= 1'b0; st <= ENG_RX;
            end
          end
          ENG_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= ENG_MACK;
            end else begin
              sda_oe <= ~sr[6]; sr <= {sr[6:0], 1'b0}; cnt <= cnt + 1'b1;
            end
          end
          ENG_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                sr <= tx_data; tx_load <= 1'b1; sda_oe <= ~tx_data[7]; st <= ENG_TX;
              end else st <= ENG_IDLE;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cq_quad_addr_slave.sv
module i2cq_quad_addr_slave #(
  parameter int WIN_EDGES  = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic       busy_i,
  input  logic       refuse_i,
  input  logic [7:0] tx_data_i,
  output logic       sda_oe_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       tx_load_o,
  output logic       addr_ready_o,
  output logic [6:0] dev_addr_o
);
  import i2cq_pkg::*;
  localparam int NSTRAP = 2;

  logic scl_s, sda_s, scl_rise_ev, scl_fall_ev, sda_edge_ev, start_ev, stop_ev;
  logic [NSTRAP-1:0] strap_s, strap_rdy;
  logic [1:0] strap_code [NSTRAP];

  i2cq_bus_edges #(.NSTRAP(NSTRAP), .DEPTH(SYNC_DEPTH)) edges_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .strap_i(strap_i),
    .scl_s(scl_s), .sda_s(sda_s), .strap_s(strap_s),
    .scl_rise(scl_rise_ev), .scl_fall(scl_fall_ev), .sda_edge(sda_edge_ev),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  for (genvar p = 0; p < NSTRAP; p++) begin : g_strap
    i2cq_strap_classify #(.WIN_EDGES(WIN_EDGES)) cls_i (
      .clk(clk), .rst_n(rst_n), .strap_s(strap_s[p]), .scl_s(scl_s), .sda_s(sda_s),
      .scl_edge(scl_rise_ev | scl_fall_ev), .sda_edge(sda_edge_ev),
      .code(strap_code[p]), .ready(strap_rdy[p])
    );
  end

  assign addr_ready_o = &strap_rdy;
  assign dev_addr_o   = build_addr(strap_code[1], strap_code[0]);

  i2cq_byte_engine eng_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise_ev), .scl_fall(scl_fall_ev),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .dev_addr(dev_addr_o), .addr_ready(addr_ready_o),
    .busy(busy_i), .refuse(refuse_i), .tx_data(tx_data_i),
    .sda_oe(sda_oe_o), .rx_data(rx_data_o), .rx_valid(rx_valid_o), .tx_load(tx_load_o)
  );
endmodule

// File: rtl/i2cq_slave_checker.sv
module i2cq_slave_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe_o,
  input logic       addr_ready_o,
  input logic [6:0] dev_addr_o,
  input logic       rx_valid_o,
  input logic       tx_load_o,
  input logic       busy_i,
  input logic       refuse_i,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       scl_fall_ev
);
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe_o); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe_o); // R8
  AST_OE_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall_ev || start_ev || stop_ev)); // R10
  AST_SILENT_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ready_o |-> !sda_oe_o); // R3
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_ready_o) |-> addr_ready_o && $stable(dev_addr_o)); // R2
  AST_RX_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !$past(busy_i) && !$past(refuse_i)); // R7
  AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |-> $past(scl_fall_ev)); // R5
endmodule

bind i2cq_quad_addr_slave i2cq_slave_checker chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .addr_ready_o(addr_ready_o),
  .dev_addr_o(dev_addr_o), .rx_valid_o(rx_valid_o), .tx_load_o(tx_load_o),
  .busy_i(busy_i), .refuse_i(refuse_i), .start_ev(start_ev), .stop_ev(stop_ev),
  .scl_fall_ev(scl_fall_ev)
);

// File: tb/i2cq_quad_addr_slave_tb_top.sv
module i2cq_quad_addr_slave_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] mode0 = 2'd0, mode1 = 2'd0;
  logic busy = 1'b0, refuse = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, rx_valid, tx_load, addr_ready;
  logic [7:0] rx_data;
  logic [6:0] dev_addr;
  logic scl_bus, sda_bus;
  logic [1:0] straps;
  int checks = 0, errors = 0, rx_cnt = 0, load_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #10 clk = ~clk;

  assign scl_bus = scl_m;
  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic strap_level(input logic [1:0] m, input logic c, input logic d);
    case (m)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return c;
      default: return d;
    endcase
  endfunction
  assign straps = {strap_level(mode1, scl_bus, sda_bus), strap_level(mode0, scl_bus, sda_bus)};

  i2cq_quad_addr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .strap_i(straps),
    .busy_i(busy), .refuse_i(refuse), .tx_data_i(tx_data),
    .sda_oe_o(sda_oe), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_load_o(tx_load),
    .addr_ready_o(addr_ready), .dev_addr_o(dev_addr)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_data; end
    if (tx_load) load_cnt++;
  end

  // strap mode 1, strap mode 0, expected address
  localparam logic [10:0] VEC [4] = '{
    {2'd1, 2'd0, 7'h54},
    {2'd2, 2'd1, 7'h59},
    {2'd3, 2'd2, 7'h5E},
    {2'd0, 2'd3, 7'h53}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bit_in(output logic b, output logic steady);
    logic early;
    sda_m = 1'b1; hw(); scl_m = 1'b1;
    repeat (2) @(negedge clk);
    early = sda_bus;
    repeat (H - 2) @(negedge clk);
    b = sda_bus; steady = (early == b);
    scl_m = 1'b0; hw();
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    logic a, s;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a, s);
    acked = ~a;
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] v, output logic steady);
    logic b, s;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin bit_in(b, s); v[i] = b; steady &= s; end
    bit_out(~master_ack);
  endtask

  task automatic do_reset(input logic [1:0] m0, input logic [1:0] m1);
    rst_n = 1'b0; mode0 = m0; mode1 = m1; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic ack, steady;
    logic [7:0] rb;
    int rx0, ld0;
    do_reset(2'd0, 2'd0);
    chk("R3 reset ready", addr_ready, 0);
    chk("R10 reset oe", sda_oe, 0);
    chk("R4 reset rx_valid", rx_valid, 0);

    for (int v = 0; v < 4; v++) begin
      do_reset(VEC[v][8:7], VEC[v][10:9]);
      i2c_start(); write_byte({VEC[v][6:0], 1'b0}, ack); i2c_stop();
      chk("R3 no ack during window", ack, 0);
      chk("R3 ready after window", addr_ready, 1);
      chk("R2 strap decode", dev_addr, VEC[v][6:0]);
      i2c_start(); write_byte({VEC[v][6:0], 1'b0}, ack); i2c_stop();
      chk("R1 matching address acked", ack, 1);
    end

    // straps now: strap0 follows data line, strap1 low -> 0x53
    i2c_start(); write_byte(8'hA6, ack);
    chk("R1 address ack", ack, 1);
    write_byte(8'hC3, ack);
    chk("R4 data ack", ack, 1);
    chk("R4 data byte", rx_last, 8'hC3);
    write_byte(8'h3C, ack);
    chk("R4 second byte", rx_last, 8'h3C);
    chk("R4 pulse count", rx_cnt, 2);
    i2c_stop();

    rx0 = rx_cnt;
    i2c_start(); write_byte(8'hA4, ack);
    chk("R1 wrong address nack", ack, 0);
    write_byte(8'h00, ack);
    chk("R9 stays released", ack, 0);
    chk("R9 no rx after mismatch", rx_cnt, rx0);
    i2c_stop();

    busy = 1'b1;
    i2c_start(); write_byte(8'hA6, ack); i2c_stop();
    chk("R7 busy nacks address", ack, 0);
    busy = 1'b0;
    i2c_start(); write_byte(8'hA6, ack);
    refuse = 1'b1; rx0 = rx_cnt;
    write_byte(8'h77, ack);
    chk("R7 refuse nacks data", ack, 0);
    chk("R7 refused byte not delivered", rx_cnt, rx0);
    refuse = 1'b0; i2c_stop();

    tx_data = 8'hA6; ld0 = load_cnt;
    i2c_start(); write_byte(8'hA7, ack);
    chk("R5 read address ack", ack, 1);
    chk("R5 tx load pulse", load_cnt, ld0 + 1);
    tx_data = 8'h5B;
    read_byte(1'b1, rb, steady);
    chk("R5 first read byte", rb, 8'hA6);
    chk("R10 stable while clock high", steady, 1);
    read_byte(1'b0, rb, steady);
    chk("R6 second byte after master ack", rb, 8'h5B);
    read_byte(1'b1, rb, steady);
    chk("R6 released after master nack", rb, 8'hFF);
    i2c_stop();

    i2c_start(); write_byte(8'hA6, ack); write_byte(8'h11, ack);
    i2c_start(); tx_data = 8'h3D; write_byte(8'hA7, ack);
    chk("R8 repeated start address ack", ack, 1);
    read_byte(1'b0, rb, steady);
    chk("R8 read after repeated start", rb, 8'h3D);
    i2c_stop();

    i2c_start(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    i2c_start(); write_byte(8'hA6, ack);
    chk("R8 start mid-byte restarts address", ack, 1);
    write_byte(8'h42, ack);
    chk("R8 data after restart", rx_last, 8'h42);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk("R8 released after stop", sda_oe, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule